// File: doc/BRIEF.md
# Clock/CMOS Index-Data Register Port

This block is the host-facing side of a 128-byte clock and configuration store. The host sees two byte addresses. The even address holds a 7-bit pointer into the store. The odd address reads or writes the byte that the pointer selects. Read data is registered: it is valid in the cycle after the read strobe. The port enforces access rules for the four control bytes. It keeps an interrupt-flag byte that clears when read, and it maintains a 16-bit additive checksum over the configuration bytes 0x10 to 0x2D.

Towards the timekeeping logic, the port provides three outputs and two kinds of input. The outputs are a set-mode level, a one-cycle pulse that asks for the time bytes to be reloaded, and a level-sensitive interrupt line. The inputs are event strobes that raise the interrupt flags, and set/clear strobes for the update-in-progress bit. The checksum is rebuilt by walking the range one byte per clock. While the walk runs, a busy output is high and host writes are held off. A host that keeps its write strobe asserted has the write accepted on the first cycle in which busy is low.

Top module: `cmos_port`

## Requirements
- R1: After reset, control byte 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00 and 0x0D reads 0x80; irq, sum_busy and set_mode are low.
- R2: A write to the even address (host_a0=0) stores bits 6:0 of the data as the pointer and drops bit 7. A read of the even address returns 0xFF. Every read returns its data on host_rdata one cycle after the strobe.
- R3: Host writes to bytes 0x0C and 0x0D have no effect.
- R4: A read of byte 0x0C returns the value it held before that read, then clears it to 0x00. The clear drops irq unless a new event arrives in the same cycle.
- R5: In byte 0x0C, flag_evt[2] sets bit 6, flag_evt[1] sets bit 5 and flag_evt[0] sets bit 4. These flags are set whether or not they are enabled. Bits 6:4 of byte 0x0B enable the flag in the same bit position. Bit 7 of 0x0C and the irq output are high while any enabled flag is set. An event that arrives in the same cycle as a clearing read survives that read.
- R6: Bit 7 of byte 0x0A (update in progress) ignores host writes; a host write changes only bits 6:0. uip_set raises the bit only while 0x0B bit 7 is clear. uip_clr lowers it.
- R7: A host write to 0x0B with data bit 7 set clears the update-in-progress bit. This clear wins over a uip_set in the same cycle.
- R8: A host write to a time byte (0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09) while 0x0B bit 7 is clear raises time_load for exactly one cycle, in the cycle after the write. Writes to the alarm bytes, or any write made while bit 7 is set, leave time_load low.
- R9: A host write that takes 0x0B bit 7 from 1 to 0 raises time_load for one cycle.
- R10: A host write to any byte in 0x10..0x2D starts a checksum rebuild. When it ends, 0x2E holds the high byte and 0x2F the low byte of the unsigned 16-bit sum of bytes 0x10..0x2D. Writes outside the range, including writes to 0x2E and 0x2F, start no rebuild.
- R11: sum_busy is high for exactly 30 cycles, starting in the cycle after the triggering write. A host write, to either address, is not accepted while sum_busy is high. A held write strobe takes effect on the first edge at which sum_busy is low.
- R12: set_mode always equals bit 7 of byte 0x0B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_a0 | input | 1 | Address bit 0: 0 = pointer, 1 = data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| sum_busy | output | 1 | Checksum rebuild in progress; writes held off |
| irq | output | 1 | Interrupt, high while an enabled flag is pending |
| set_mode | output | 1 | Copy of byte 0x0B bit 7 |
| time_load | output | 1 | One-cycle request to reload time bytes |
| uip_set | input | 1 | Raise the update-in-progress bit |
| uip_clr | input | 1 | Lower the update-in-progress bit |
| flag_evt | input | 3 | Event strobes: [2] periodic, [1] alarm, [0] update done |

## Verification
A clearing read of byte 0x0C and a flag event can fall in the same cycle. The bench provokes this by first leaving a flag pending that is not enabled. It then drives the read strobe and an enabled alarm event on the same clock edge. The read must return only the earlier flag, and afterwards irq must be high and a second read must show the new alarm flag. A second overlap is a write strobe held during a checksum walk. The bench checks that the pointer moves only after sum_busy falls.

// File: rtl/cmos_port_pkg.sv
package cmos_port_pkg;

   // control byte positions decoded by the port
   localparam int unsigned CTL_A_IX = 32'h0A;
   localparam int unsigned CTL_B_IX = 32'h0B;
   localparam int unsigned FLAG_IX  = 32'h0C;
   localparam int unsigned STAT_IX  = 32'h0D;

   // number of interrupt sources held in the flag byte
   localparam int unsigned NUM_FLAGS = 3;

   // time bytes whose host write asks the time engine to reload
   function automatic logic is_time_ix(int unsigned ix);
      return (ix == 0) || (ix == 2) || (ix == 4) ||
             (ix == 6) || (ix == 7) || (ix == 8) || (ix == 9);
   endfunction

endpackage

// File: rtl/cmos_hostif.sv
module cmos_hostif #(
   parameter int unsigned IW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_a0,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [7:0]    host_wdata,
   input  logic          hold,
   output logic [IW-1:0] idx,
   output logic          data_we,
   output logic          data_re
);

   logic ptr_we;

   assign ptr_we  = host_wr && !host_a0 && !hold;
   assign data_we = host_wr &&  host_a0 && !hold;
   assign data_re = host_rd &&  host_a0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (ptr_we)
         idx <= host_wdata[IW-1:0];
   end

endmodule

// File: rtl/cmos_sum_walk.sv
module cmos_sum_walk #(
   parameter int unsigned IW    = 7,
   parameter int unsigned FIRST = 32'h10,
   parameter int unsigned LAST  = 32'h2D,
   parameter int unsigned SW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    byte_in,
   output logic [IW-1:0] ptr,
   output logic          busy,
   output logic          commit,
   output logic [SW-1:0] total
);

   localparam logic [IW-1:0] PTR_FIRST = IW'(FIRST);
   localparam logic [IW-1:0] PTR_LAST  = IW'(LAST);

   logic [SW-1:0] acc;

   assign commit = busy && (ptr == PTR_LAST);
   assign total  = acc + SW'(byte_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= PTR_FIRST;
         acc  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            ptr  <= PTR_FIRST;
            acc  <= '0;
         end
      end else begin
         acc <= total;
         if (commit)
            busy <= 1'b0;
         else
            ptr <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/cmos_irq_flags.sv
module cmos_irq_flags #(
   parameter int unsigned NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] evt,
   input  logic [NF-1:0] en,
   input  logic          clr,
   output logic [NF-1:0] flags,
   output logic          pend
);

   for (genvar g = 0; g < NF; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            flags[g] <= 1'b0;
         else
            flags[g] <= (flags[g] && !clr) || evt[g];
      end
   end

   assign pend = |(flags & en);

endmodule

// File: rtl/cmos_port.sv
module cmos_port
   import cmos_port_pkg::*;
#(
   parameter int unsigned DEPTH     = 128,
   parameter int unsigned SUM_FIRST = 32'h10,
   parameter int unsigned SUM_LAST  = 32'h2D,
   parameter int unsigned SUM_HI_IX = 32'h2E,
   parameter int unsigned SUM_LO_IX = 32'h2F,
   parameter logic [7:0]  A_RESET   = 8'h26,
   parameter logic [7:0]  B_RESET   = 8'h02,
   parameter logic [7:0]  D_VALUE   = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_a0,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic       sum_busy,
   output logic       irq,
   output logic       set_mode,
   output logic       time_load,
   input  logic       uip_set,
   input  logic       uip_clr,
   input  logic [2:0] flag_evt
);

   localparam int unsigned IW = $clog2(DEPTH);
   localparam int unsigned NF = NUM_FLAGS;
   localparam logic [IW-1:0] IXA   = IW'(CTL_A_IX);
   localparam logic [IW-1:0] IXB   = IW'(CTL_B_IX);
   localparam logic [IW-1:0] IXC   = IW'(FLAG_IX);
   localparam logic [IW-1:0] IXD   = IW'(STAT_IX);
   localparam logic [IW-1:0] IXF   = IW'(SUM_FIRST);
   localparam logic [IW-1:0] IXL   = IW'(SUM_LAST);
   localparam logic [IW-1:0] IXHI  = IW'(SUM_HI_IX);
   localparam logic [IW-1:0] IXLO  = IW'(SUM_LO_IX);

   if (DEPTH != (1 << IW) || DEPTH < 16) begin : g_bad_depth
      $error("cmos_port: DEPTH must be a power of two of at least 16");
   end
   if (SUM_LAST < SUM_FIRST || SUM_LAST >= DEPTH) begin : g_bad_range
      $error("cmos_port: checksum range out of order or outside the store");
   end
   if (SUM_HI_IX >= DEPTH || SUM_LO_IX >= DEPTH ||
       (SUM_HI_IX >= SUM_FIRST && SUM_HI_IX <= SUM_LAST) ||
       (SUM_LO_IX >= SUM_FIRST && SUM_LO_IX <= SUM_LAST)) begin : g_bad_sum
      $error("cmos_port: checksum bytes must lie in the store and outside the range");
   end

   logic [7:0]    mem [DEPTH];
   logic [IW-1:0] idx;
   logic          data_we;
   logic          data_re;
   logic [6:0]    a_low;
   logic          uip_q;
   logic [7:0]    reg_b;
   logic [NF-1:0] c_flags;
   logic          c_pend;
   logic          c_clr;
   logic [7:0]    c_val;
   logic [7:0]    rd_mux;
   logic          sum_start;
   logic [IW-1:0] walk_ptr;
   logic          sum_commit;
   logic [15:0]   sum_total;
   logic          b_write;

   cmos_hostif #(.IW(IW)) u_hostif (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_a0    (host_a0),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .hold       (sum_busy),
      .idx        (idx),
      .data_we    (data_we),
      .data_re    (data_re)
   );

   assign sum_start = data_we && (idx >= IXF) && (idx <= IXL);

   cmos_sum_walk #(.IW(IW), .FIRST(SUM_FIRST), .LAST(SUM_LAST), .SW(16)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sum_start),
      .byte_in (mem[walk_ptr]),
      .ptr     (walk_ptr),
      .busy    (sum_busy),
      .commit  (sum_commit),
      .total   (sum_total)
   );

   assign c_clr = data_re && (idx == IXC);

   cmos_irq_flags #(.NF(NF)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (flag_evt),
      .en    (reg_b[6:4]),
      .clr   (c_clr),
      .flags (c_flags),
      .pend  (c_pend)
   );

   assign c_val    = {c_pend, c_flags, 4'b0000};
   assign irq      = c_pend;
   assign set_mode = reg_b[7];
   assign b_write  = data_we && (idx == IXB);

   // read path
   always_comb begin
      case (idx)
         IXA:     rd_mux = {uip_q, a_low};
         IXB:     rd_mux = reg_b;
         IXC:     rd_mux = c_val;
         IXD:     rd_mux = D_VALUE;
         default: rd_mux = mem[idx];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (host_rd)
         host_rdata <= host_a0 ? rd_mux : 8'hFF;
   end

   // update-in-progress bit: host set-mode write wins, then clear, then set
   always_ff @(posedge clk) begin
      if (!rst_n)
         uip_q <= A_RESET[7];
      else if (b_write && host_wdata[7])
         uip_q <= 1'b0;
      else if (uip_clr)
         uip_q <= 1'b0;
      else if (uip_set && !reg_b[7])
         uip_q <= 1'b1;
   end

   // control bytes and reload request
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_low     <= A_RESET[6:0];
         reg_b     <= B_RESET;
         time_load <= 1'b0;
      end else begin
         time_load <= 1'b0;
         if (data_we) begin
            if (idx == IXA)
               a_low <= host_wdata[6:0];
            if (idx == IXB) begin
               reg_b <= host_wdata;
               if (reg_b[7] && !host_wdata[7])
                  time_load <= 1'b1;
            end
            if (is_time_ix(int'(idx)) && !reg_b[7])
               time_load <= 1'b1;
         end
      end
   end

   // general store and checksum bytes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else begin
         if (data_we && idx != IXA && idx != IXB && idx != IXC && idx != IXD)
            mem[idx] <= host_wdata;
         if (sum_commit) begin
            mem[IXHI] <= sum_total[15:8];
            mem[IXLO] <= sum_total[7:0];
         end
      end
   end

endmodule

// File: rtl/cmos_port_chk.sv
module cmos_port_chk
   import cmos_port_pkg::*;
#(
   parameter int unsigned IW    = 7,
   parameter int unsigned FIRST = 32'h10,
   parameter int unsigned LAST  = 32'h2D
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_a0,
   input logic          host_wr,
   input logic          host_rd,
   input logic [7:0]    host_wdata,
   input logic [7:0]    host_rdata,
   input logic          sum_busy,
   input logic          irq,
   input logic          time_load,
   input logic [2:0]    flag_evt,
   input logic [IW-1:0] idx,
   input logic [7:0]    reg_b,
   input logic          uip_q,
   input logic [2:0]    c_flags
);

   localparam logic [IW-1:0] K_B = IW'(CTL_B_IX);
   localparam logic [IW-1:0] K_C = IW'(FLAG_IX);
   localparam logic [IW-1:0] K_F = IW'(FIRST);
   localparam logic [IW-1:0] K_L = IW'(LAST);

   // R2
   even_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !host_a0 |=> host_rdata == 8'hFF);

   // R4
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_a0 && idx == K_C && flag_evt == 3'b000 |=> !irq && c_flags == 3'b000);

   // R3
   flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_a0 && !sum_busy && !host_rd && idx == K_C && flag_evt == 3'b000
      |=> $stable(c_flags));

   // R7
   setmode_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_a0 && !sum_busy && idx == K_B && host_wdata[7] |=> !uip_q);

   // R8
   time_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_a0 && !sum_busy && !reg_b[7] && is_time_ix(int'(idx)) |=> time_load);

   // R10
   sum_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && host_a0 && !sum_busy && idx >= K_F && idx <= K_L |=> sum_busy);

   // R11
   stall_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_busy && host_wr && !host_a0 |=> $stable(idx));

endmodule

bind cmos_port cmos_port_chk #(.IW(IW), .FIRST(SUM_FIRST), .LAST(SUM_LAST)) u_chk (.*);

// File: tb/cmos_port_tb.sv
module cmos_port_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_a0 = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       sum_busy;
   logic       irq;
   logic       set_mode;
   logic       time_load;
   logic       uip_set = 1'b0;
   logic       uip_clr = 1'b0;
   logic [2:0] flag_evt = 3'b000;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmos_port u_dut (
      .clk(clk), .rst_n(rst_n), .host_a0(host_a0), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sum_busy(sum_busy), .irq(irq), .set_mode(set_mode), .time_load(time_load),
      .uip_set(uip_set), .uip_clr(uip_clr), .flag_evt(flag_evt)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic bus_write(input logic a0, input logic [7:0] d);
      while (sum_busy) @(negedge clk);
      host_a0 = a0; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a0, output logic [7:0] d);
      host_a0 = a0; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic reg_write(input logic [6:0] ix, input logic [7:0] d);
      bus_write(1'b0, {1'b0, ix});
      bus_write(1'b1, d);
   endtask

   task automatic reg_read(input logic [6:0] ix, output logic [7:0] d);
      bus_write(1'b0, {1'b0, ix});
      bus_read(1'b1, d);
   endtask

   task automatic pulse_uip(input logic set, input logic clr);
      uip_set = set; uip_clr = clr;
      @(negedge clk);
      uip_set = 1'b0; uip_clr = 1'b0;
   endtask

   task automatic pulse_evt(input logic [2:0] e);
      flag_evt = e;
      @(negedge clk);
      flag_evt = 3'b000;
   endtask

   task automatic wait_idle();
      while (sum_busy) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 irq", 16'(irq), 16'h0);
      check("R1 busy", 16'(sum_busy), 16'h0);
      check("R1 set_mode", 16'(set_mode), 16'h0);
      reg_read(7'h0A, d); check("R1 byte 0x0A", 16'(d), 16'h26);
      reg_read(7'h0B, d); check("R1 byte 0x0B", 16'(d), 16'h02);
      reg_read(7'h0C, d); check("R1 byte 0x0C", 16'(d), 16'h00);
      reg_read(7'h0D, d); check("R1 byte 0x0D", 16'(d), 16'h80);
   endtask

   task automatic t_index();
      logic [7:0] d;
      bus_read(1'b0, d); check("R2 even read", 16'(d), 16'hFF);
      bus_write(1'b0, 8'h8A);
      bus_read(1'b1, d); check("R2 pointer bit7 dropped", 16'(d), 16'h26);
      reg_write(7'h40, 8'h5A);
      reg_read(7'h40, d); check("R2 plain byte", 16'(d), 16'h5A);
   endtask

   task automatic t_readonly();
      logic [7:0] d;
      reg_write(7'h0C, 8'hFF);
      check("R3 irq after flag write", 16'(irq), 16'h0);
      reg_read(7'h0C, d); check("R3 byte 0x0C", 16'(d), 16'h00);
      reg_write(7'h0D, 8'h00);
      reg_read(7'h0D, d); check("R3 byte 0x0D", 16'(d), 16'h80);
   endtask

   task automatic t_uip();
      logic [7:0] d;
      pulse_uip(1'b1, 1'b0);
      reg_read(7'h0A, d); check("R6 uip set", 16'(d), 16'hA6);
      reg_write(7'h0A, 8'h05);
      reg_read(7'h0A, d); check("R6 uip kept on write", 16'(d), 16'h85);
      reg_write(7'h0B, 8'h82);
      check("R12 set_mode high", 16'(set_mode), 16'h1);
      reg_read(7'h0A, d); check("R7 uip cleared", 16'(d), 16'h05);
      pulse_uip(1'b1, 1'b0);
      reg_read(7'h0A, d); check("R6 uip_set ignored in set mode", 16'(d), 16'h05);
      reg_write(7'h0B, 8'h02);
      check("R9 reload on leaving set mode", 16'(time_load), 16'h1);
      check("R12 set_mode low", 16'(set_mode), 16'h0);
      pulse_uip(1'b1, 1'b0);
      reg_read(7'h0A, d); check("R6 uip set again", 16'(d), 16'h85);
      reg_write(7'h0A, 8'h80);
      reg_read(7'h0A, d); check("R6 host cannot clear uip", 16'(d), 16'h80);
      pulse_uip(1'b0, 1'b1);
      reg_read(7'h0A, d); check("R6 uip cleared by input", 16'(d), 16'h00);
   endtask

   task automatic t_time();
      reg_write(7'h00, 8'h30);
      check("R8 seconds write reload", 16'(time_load), 16'h1);
      @(negedge clk);
      check("R8 reload one cycle", 16'(time_load), 16'h0);
      reg_write(7'h01, 8'h30);
      check("R8 alarm write no reload", 16'(time_load), 16'h0);
      reg_write(7'h0B, 8'h82);
      check("R9 entering set mode no reload", 16'(time_load), 16'h0);
      reg_write(7'h04, 8'h12);
      check("R8 no reload in set mode", 16'(time_load), 16'h0);
      reg_write(7'h0B, 8'h02);
      check("R9 leaving set mode reload", 16'(time_load), 16'h1);
   endtask

   task automatic t_sum();
      logic [7:0] d;
      int n;
      reg_write(7'h0F, 8'h77);
      check("R10 below range no walk", 16'(sum_busy), 16'h0);
      reg_write(7'h10, 8'hFF);
      n = 0;
      while (sum_busy) begin n++; @(negedge clk); end
      check("R11 busy length", 16'(n), 16'd30);
      reg_read(7'h2E, d); check("R10 sum high", 16'(d), 16'h00);
      reg_read(7'h2F, d); check("R10 sum low", 16'(d), 16'hFF);
      reg_write(7'h2D, 8'hFE);
      reg_write(7'h20, 8'h33);
      wait_idle();
      reg_read(7'h2E, d); check("R10 sum high 3 bytes", 16'(d), 16'h02);
      reg_read(7'h2F, d); check("R10 sum low 3 bytes", 16'(d), 16'h30);
      reg_write(7'h2E, 8'h55);
      check("R10 write to sum byte no walk", 16'(sum_busy), 16'h0);
      reg_read(7'h2E, d); check("R10 sum byte host value", 16'(d), 16'h55);
      reg_write(7'h11, 8'h01);
      wait_idle();
      reg_read(7'h2E, d); check("R10 sum high refreshed", 16'(d), 16'h02);
      reg_read(7'h2F, d); check("R10 sum low refreshed", 16'(d), 16'h31);
   endtask

   task automatic t_stall();
      logic [7:0] d;
      reg_write(7'h12, 8'h10);
      check("R11 busy after write", 16'(sum_busy), 16'h1);
      host_a0 = 1'b0; host_wdata = 8'h0F; host_wr = 1'b1;
      @(negedge clk);
      check("R11 still busy while held", 16'(sum_busy), 16'h1);
      while (sum_busy) @(negedge clk);
      @(negedge clk);
      host_wr = 1'b0;
      bus_read(1'b1, d); check("R11 held pointer write landed", 16'(d), 16'h77);
      reg_read(7'h2F, d); check("R11 sum low after stall", 16'(d), 16'h41);
   endtask

   task automatic t_flags();
      logic [7:0] d;
      pulse_evt(3'b100);
      check("R5 disabled flag no irq", 16'(irq), 16'h0);
      reg_read(7'h0C, d); check("R5 periodic flag bit", 16'(d), 16'h40);
      reg_read(7'h0C, d); check("R4 cleared by read", 16'(d), 16'h00);
      reg_write(7'h0B, 8'h22);
      pulse_evt(3'b010);
      check("R5 enabled alarm irq", 16'(irq), 16'h1);
      reg_read(7'h0C, d); check("R4 read returns alarm", 16'(d), 16'hA0);
      check("R4 irq dropped", 16'(irq), 16'h0);
      // event in the same cycle as the clearing read
      pulse_evt(3'b001);
      bus_write(1'b0, 8'h0C);
      host_a0 = 1'b1; host_rd = 1'b1; flag_evt = 3'b010;
      @(negedge clk);
      host_rd = 1'b0; flag_evt = 3'b000;
      check("R5 overlap read old value", 16'(host_rdata), 16'h10);
      check("R5 overlap event survives irq", 16'(irq), 16'h1);
      bus_read(1'b1, d); check("R5 overlap event kept", 16'(d), 16'hA0);
      check("R4 irq low after final read", 16'(irq), 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_readonly();
      t_uip();
      t_time();
      t_sum();
      t_stall();
      t_flags();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule